// File: doc/BRIEF.md
# Synchronous FIFO with Reread and Rewrite Marks

This block is a single-direction synchronous first-in first-out buffer, 18 bits wide and 512 words deep by default. A write pointer and a read pointer move independently. Two saved marks sit beside them. The reread mark lets a block of already-read data be read again by moving the read pointer back. The rewrite mark lets a block of already-written data be overwritten by moving the write pointer back.

Four status flags come from the pointers: Empty, Almost-Empty, Almost-Full and Full. The almost thresholds are taken from two offset inputs, each of which may be any value from 0 to the depth. Two select inputs change what the Full and Empty comparisons use. When a select is set, the flag compares against a saved mark instead of the live opposite pointer. This keeps data that may still be reread from being overwritten, and it keeps space that may still be rewritten from being read. The flags are combinational from the registered pointers, so they change in the cycle that follows the clock edge that moved a pointer.

Each pointer is handled by a small operation decoder with three named operations. PTR_HOLD keeps the pointer. PTR_STEP advances it by one after an accepted access. PTR_LOAD reloads it from its mark. PTR_LOAD takes priority over PTR_STEP, and PTR_STEP takes priority over PTR_HOLD. Marks are captured independently of these operations.

Top module: `mark_fifo`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, both pointers and both marks are zero, rd_data is 0, empty and almost_empty are 1, and full and almost_full are 0 (with almost_full_offset below the depth).
- R2: Accepted writes are read back in the order they were written. rd_data takes the word at the read pointer at the edge of an accepted read and holds at every other edge. A read and a write in the same cycle are both accepted when the flags allow them.
- R3: A write while full is 1 stores nothing and does not move the write pointer. A read while empty is 1 does not move the read pointer and leaves rd_data unchanged.
- R4: With full_sel=0, full is 1 when the write pointer minus the read pointer is the depth or more. With full_sel=1, full is 1 when the write pointer minus the reread mark is the depth or more.
- R5: With empty_sel=0, empty is 1 when the read pointer equals the write pointer. With empty_sel=1, empty is 1 when the read pointer has reached or passed the rewrite mark.
- R6: almost_empty is 1 exactly when the fill (write pointer minus read pointer) is less than or equal to almost_empty_offset. An offset of the depth keeps it at 1 at every fill.
- R7: almost_full is 1 exactly when the fill is greater than or equal to the depth minus almost_full_offset. An offset of 0 sets it only at a full buffer. An offset of the depth keeps it at 1 at every fill.
- R8: mark_reread captures the read pointer into the reread mark. do_reread loads the read pointer from the reread mark, and a read requested in that cycle is ignored.
- R9: mark_rewrite captures the write pointer into the rewrite mark. do_rewrite loads the write pointer from the rewrite mark, and a write requested in that cycle is ignored.
- R10: When a capture and a restore of the same mark happen in one cycle, the restore uses the mark value from before the edge, and the mark takes the pointer value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH (18) | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH (18) | Last word read |
| mark_reread | input | 1 | Capture the read pointer into the reread mark |
| mark_rewrite | input | 1 | Capture the write pointer into the rewrite mark |
| do_reread | input | 1 | Load the read pointer from the reread mark |
| do_rewrite | input | 1 | Load the write pointer from the rewrite mark |
| full_sel | input | 1 | 0: Full compares against the read pointer; 1: against the reread mark |
| empty_sel | input | 1 | 0: Empty compares against the write pointer; 1: against the rewrite mark |
| almost_empty_offset | input | log2(DEPTH)+1 (10) | Almost-Empty threshold, 0 to DEPTH |
| almost_full_offset | input | log2(DEPTH)+1 (10) | Almost-Full distance from the top, 0 to DEPTH |
| empty | output | 1 | Empty flag |
| almost_empty | output | 1 | Almost-Empty flag |
| almost_full | output | 1 | Almost-Full flag |
| full | output | 1 | Full flag |

## Verification
The buffer is tried with several input patterns. Short write bursts followed by reads check ordering. Overlapping reads and writes show that simultaneous access is accepted on both sides. A complete fill with extra writes on top separates an ignored write from one that overwrites stored data. Reads on an empty buffer show that rd_data holds. The mark patterns compare each select setting against the live-pointer setting. One pattern shows Full arriving early when it is measured from a reread mark. Another shows Empty arriving while data remains, when it is measured from a rewrite mark. Restores issued together with reads, writes or captures of the same mark show the ordering between operations within one cycle. The offsets are also tried at 0 and at the depth, which shows the threshold boundaries.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_STEP = 2'd1,
        PTR_LOAD = 2'd2
    } ptr_op_e;
endpackage

// File: rtl/mark_fifo_ptr.sv
module mark_fifo_ptr
    import mark_fifo_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             capture,
    input  logic             restore,
    output logic [CNT_W-1:0] ptr,
    output logic [CNT_W-1:0] mark
);
    ptr_op_e          op;
    logic [CNT_W-1:0] ptr_nxt;

    // operation select: a restore beats a step
    always_comb begin
        if (restore)   op = PTR_LOAD;
        else if (step) op = PTR_STEP;
        else           op = PTR_HOLD;
    end

    always_comb begin
        unique case (op)
            PTR_HOLD: ptr_nxt = ptr;
            PTR_STEP: ptr_nxt = ptr + CNT_W'(1);
            PTR_LOAD: ptr_nxt = mark;
            default:  ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            mark <= '0;
        end else begin
            ptr <= ptr_nxt;
            if (capture) mark <= ptr;
        end
    end
endmodule

// File: rtl/mark_fifo_store.sv
module mark_fifo_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_go,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_go) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/mark_fifo_flags.sv
module mark_fifo_flags #(
    parameter int DEPTH = 512,
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] wr_ptr,
    input  logic [CNT_W-1:0] rd_ptr,
    input  logic [CNT_W-1:0] rr_mark,
    input  logic [CNT_W-1:0] rw_mark,
    input  logic             full_sel,
    input  logic             empty_sel,
    input  logic [CNT_W-1:0] ae_off,
    input  logic [CNT_W-1:0] af_off,
    output logic             empty,
    output logic             almost_empty,
    output logic             almost_full,
    output logic             full
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] fill, full_dist, empty_dist;

    always_comb begin
        fill       = wr_ptr - rd_ptr;
        full_dist  = wr_ptr - (full_sel ? rr_mark : rd_ptr);
        empty_dist = (empty_sel ? rw_mark : wr_ptr) - rd_ptr;
        full         = (full_dist >= DEPTH_C);
        // zero distance, or a distance past the depth (pointer went beyond)
        empty        = (empty_dist == '0) || (empty_dist > DEPTH_C);
        almost_empty = (fill <= ae_off);
        almost_full  = (fill >= (DEPTH_C - af_off));
    end
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    output logic [WIDTH-1:0]         rd_data,
    input  logic                     mark_reread,
    input  logic                     mark_rewrite,
    input  logic                     do_reread,
    input  logic                     do_rewrite,
    input  logic                     full_sel,
    input  logic                     empty_sel,
    input  logic [$clog2(DEPTH):0]   almost_empty_offset,
    input  logic [$clog2(DEPTH):0]   almost_full_offset,
    output logic                     empty,
    output logic                     almost_empty,
    output logic                     almost_full,
    output logic                     full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [CNT_W-1:0] wr_ptr, rd_ptr, rr_mark, rw_mark;
    logic             wr_go, rd_go;

    assign wr_go = wr_en && !full  && !do_rewrite;
    assign rd_go = rd_en && !empty && !do_reread;

    mark_fifo_ptr #(.CNT_W(CNT_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(wr_go), .capture(mark_rewrite),
        .restore(do_rewrite), .ptr(wr_ptr), .mark(rw_mark)
    );

    mark_fifo_ptr #(.CNT_W(CNT_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step(rd_go), .capture(mark_reread),
        .restore(do_reread), .ptr(rd_ptr), .mark(rr_mark)
    );

    mark_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .wr_idx(wr_ptr[PTR_W-1:0]), .wr_data(wr_data),
        .rd_go(rd_go), .rd_idx(rd_ptr[PTR_W-1:0]), .rd_data(rd_data)
    );

    mark_fifo_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rr_mark(rr_mark), .rw_mark(rw_mark),
        .full_sel(full_sel), .empty_sel(empty_sel),
        .ae_off(almost_empty_offset), .af_off(almost_full_offset),
        .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .full(full)
    );
endmodule

// File: rtl/mark_fifo_chk.sv
module mark_fifo_chk #(
    parameter int WIDTH = 18,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             mark_reread,
    input logic             mark_rewrite,
    input logic             do_reread,
    input logic             do_rewrite,
    input logic             full_sel,
    input logic             empty_sel,
    input logic             empty,
    input logic             almost_empty,
    input logic             almost_full,
    input logic             full,
    input logic [WIDTH-1:0] rd_data,
    input logic [CNT_W-1:0] wr_ptr,
    input logic [CNT_W-1:0] rd_ptr,
    input logic [CNT_W-1:0] rr_mark,
    input logic [CNT_W-1:0] rw_mark
);
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !do_rewrite |=> wr_ptr == $past(wr_ptr)); // R3
    AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !do_reread |=> rd_ptr == $past(rd_ptr)); // R3
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !empty && !do_reread) |=> $stable(rd_data)); // R2
    AST_REREAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        do_reread |=> rd_ptr == $past(rr_mark)); // R8
    AST_REWRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        do_rewrite |=> wr_ptr == $past(rw_mark)); // R9
    AST_REREAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_reread |=> rr_mark == $past(rd_ptr)); // R10
    AST_REWRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_rewrite |=> rw_mark == $past(wr_ptr)); // R9
    AST_EMPTY_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_sel && empty |-> almost_empty); // R6
    AST_FULL_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !full_sel && full |-> almost_full); // R7
endmodule

bind mark_fifo mark_fifo_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .mark_reread(mark_reread), .mark_rewrite(mark_rewrite),
    .do_reread(do_reread), .do_rewrite(do_rewrite),
    .full_sel(full_sel), .empty_sel(empty_sel),
    .empty(empty), .almost_empty(almost_empty),
    .almost_full(almost_full), .full(full), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rr_mark(rr_mark), .rw_mark(rw_mark)
);

// File: tb/sim_mark_fifo.sv
`timescale 1ns/1ps
module sim_mark_fifo;
    localparam int W  = 18;
    localparam int D  = 512;
    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, mark_reread = 0, mark_rewrite = 0;
    logic do_reread = 0, do_rewrite = 0, full_sel = 0, empty_sel = 0;
    logic [W-1:0]  wr_data = '0;
    logic [CW-1:0] almost_empty_offset = CW'(3);
    logic [CW-1:0] almost_full_offset  = CW'(4);
    logic [W-1:0]  rd_data;
    logic          empty, almost_empty, almost_full, full;

    always #10 clk = ~clk;

    mark_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .mark_reread(mark_reread), .mark_rewrite(mark_rewrite),
        .do_reread(do_reread), .do_rewrite(do_rewrite),
        .full_sel(full_sel), .empty_sel(empty_sel),
        .almost_empty_offset(almost_empty_offset),
        .almost_full_offset(almost_full_offset),
        .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .full(full)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural model: unbounded integer positions
    int m_w, m_r, m_mr, m_mw;
    logic [W-1:0] m_mem [D];
    logic [W-1:0] m_rd;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit m_full();
        int refp = full_sel ? m_mr : m_r;
        return (m_w - refp) >= D;
    endfunction

    function automatic bit m_empty();
        int refp = empty_sel ? m_mw : m_w;
        return (refp - m_r) <= 0;
    endfunction

    task automatic compare_all();
        bit e = m_empty();
        bit f = m_full();
        bit ae = (m_w - m_r) <= int'(almost_empty_offset);
        bit af = (m_w - m_r) >= D - int'(almost_full_offset);
        chk(empty == e, "R5 empty", empty, e);
        chk(full == f, "R4 full", full, f);
        chk(almost_empty == ae, "R6 almost_empty", almost_empty, ae);
        chk(almost_full == af, "R7 almost_full", almost_full, af);
        chk(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
    endtask

    task automatic cyc(input bit we, input logic [W-1:0] wd, input bit re,
                       input bit mrr, input bit mrw, input bit drr, input bit drw);
        bit wg, rg;
        int w0, r0;
        wg = we && !m_full() && !drw;
        rg = re && !m_empty() && !drr;
        wr_en = we; wr_data = wd; rd_en = re;
        mark_reread = mrr; mark_rewrite = mrw; do_reread = drr; do_rewrite = drw;
        @(posedge clk);
        w0 = m_w; r0 = m_r;
        if (rg) begin m_rd = m_mem[r0 % D]; m_r = r0 + 1; end
        if (wg) begin m_mem[w0 % D] = wd; m_w = w0 + 1; end
        if (drr) m_r = m_mr;
        if (drw) m_w = m_mw;
        if (mrr) m_mr = r0;
        if (mrw) m_mw = w0;
        @(negedge clk);
        wr_en = 0; rd_en = 0; mark_reread = 0; mark_rewrite = 0;
        do_reread = 0; do_rewrite = 0;
        compare_all();
    endtask

    task automatic wr(input logic [W-1:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
    task automatic rd();                       cyc(0, '0, 1, 0, 0, 0, 0); endtask

    task automatic do_reset();
        rst_n = 0;
        full_sel = 0; empty_sel = 0;
        almost_empty_offset = CW'(3); almost_full_offset = CW'(4);
        repeat (2) @(posedge clk);
        m_w = 0; m_r = 0; m_mr = 0; m_mw = 0; m_rd = '0;
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(empty == 1'b1, "R1 reset empty", empty, 1);
        chk(almost_empty == 1'b1, "R1 reset almost_empty", almost_empty, 1);
        chk(full == 1'b0, "R1 reset full", full, 0);
        chk(almost_full == 1'b0, "R1 reset almost_full", almost_full, 0);
        chk(rd_data == '0, "R1 reset rd_data", rd_data, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R2: short burst then drain
        for (int i = 0; i < 10; i++) wr(W'(18'h100 + i));
        for (int i = 0; i < 10; i++) rd();
        chk(rd_data == W'(18'h109), "R2 last of burst", rd_data, 18'h109);

        // R3: reads on an empty buffer hold rd_data
        for (int i = 0; i < 3; i++) rd();
        chk(rd_data == W'(18'h109), "R3 empty read holds", rd_data, 18'h109);

        // R2: overlapping read and write
        wr(W'(18'h200)); wr(W'(18'h201));
        for (int i = 0; i < 20; i++) cyc(1, W'(18'h202 + i), 1, 0, 0, 0, 0);
        chk(rd_data == W'(18'h213), "R2 overlap order", rd_data, 18'h213);
        rd(); rd();
        chk(empty == 1'b1, "R2 overlap drained", empty, 1);

        // R3/R4/R7: full fill with extra writes
        do_reset();
        almost_full_offset = CW'(0);
        for (int i = 0; i < D; i++) wr(W'(i));
        chk(full == 1'b1, "R4 full at depth", full, 1);
        chk(almost_full == 1'b1, "R7 offset 0 at full", almost_full, 1);
        for (int i = 0; i < 5; i++) wr(W'(18'h3FFFF));
        almost_empty_offset = CW'(D);
        #1;
        chk(almost_empty == 1'b1, "R6 offset depth at full", almost_empty, 1);
        almost_empty_offset = CW'(3);
        for (int i = 0; i < D; i++) rd();
        chk(rd_data == W'(D - 1), "R3 extra writes dropped", rd_data, D - 1);
        chk(empty == 1'b1, "R3 empty after drain", empty, 1);
        rd();
        chk(rd_data == W'(D - 1), "R3 read while empty", rd_data, D - 1);
        almost_full_offset = CW'(D);
        #1;
        chk(almost_full == 1'b1, "R7 offset depth when empty", almost_full, 1);
        almost_full_offset = CW'(4);

        // R8: reread a block
        do_reset();
        for (int i = 0; i < 8; i++) wr(W'(18'h300 + i));
        rd();
        cyc(0, '0, 0, 1, 0, 0, 0);
        rd(); rd(); rd();
        cyc(0, '0, 1, 0, 0, 1, 0);
        chk(rd_data == W'(18'h303), "R8 read ignored on restore", rd_data, 18'h303);
        rd();
        chk(rd_data == W'(18'h301), "R8 reread first word", rd_data, 18'h301);

        // R9: rewrite a block
        do_reset();
        wr(W'(18'h400)); wr(W'(18'h401));
        cyc(0, '0, 0, 0, 1, 0, 0);
        wr(W'(18'h402)); wr(W'(18'h403)); wr(W'(18'h404));
        cyc(1, W'(18'h3AAAA), 0, 0, 0, 0, 1);
        wr(W'(18'h455));
        rd(); rd(); rd();
        chk(rd_data == W'(18'h455), "R9 rewritten word", rd_data, 18'h455);
        chk(empty == 1'b1, "R9 write ignored on restore", empty, 1);

        // R4: full measured from the reread mark
        do_reset();
        full_sel = 1;
        for (int i = 0; i < 10; i++) wr(W'(18'h500 + i));
        for (int i = 0; i < 5; i++) rd();
        begin
            int n = 0;
            while (!full && n < 600) begin wr(W'(n)); n++; end
            chk(n == 502, "R4 full from reread mark", n, 502);
        end
        full_sel = 0;
        #1;
        chk(full == 1'b0, "R4 live pointer not full", full, 0);

        // R5: empty measured from the rewrite mark
        do_reset();
        for (int i = 0; i < 4; i++) wr(W'(18'h600 + i));
        cyc(0, '0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) wr(W'(18'h604 + i));
        empty_sel = 1;
        #1;
        begin
            int n = 0;
            while (!empty && n < 20) begin rd(); n++; end
            chk(n == 4, "R5 empty at rewrite mark", n, 4);
        end
        chk(rd_data == W'(18'h603), "R5 last read before mark", rd_data, 18'h603);
        empty_sel = 0;
        #1;
        chk(empty == 1'b0, "R5 live pointer not empty", empty, 0);

        // R10: capture and restore in one cycle
        do_reset();
        for (int i = 0; i < 6; i++) wr(W'(18'h700 + i));
        rd(); rd();
        cyc(0, '0, 0, 1, 0, 1, 0);
        rd();
        chk(rd_data == W'(18'h700), "R10 restore used old mark", rd_data, 18'h700);
        cyc(0, '0, 0, 0, 0, 1, 0);
        rd();
        chk(rd_data == W'(18'h702), "R10 mark took old pointer", rd_data, 18'h702);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule